// File: doc/BRIEF.md
# Four-Way Page Translation Cache

This block keeps recently used translations from virtual page numbers to physical frame numbers, so that the address path can skip a page-table walk when it hits. A lookup presents a virtual page number and, in the same cycle, receives a hit flag, the physical frame number, and the writable, user and dirty attributes stored with that translation. The permission checker downstream uses these attributes on a hit. When a table walk finishes, the walker installs its result through the fill port. The block has no knowledge of address spaces. Whenever software loads a new page-table base, the flush input must be pulsed, and that invalidates the whole cache.

The storage is split into sets. A set is chosen by the low bits of the virtual page number, and the upper bits are kept as the tag. Each set holds four ways. Replacement within a set follows a three-bit tree that approximates least-recently-used order. An empty way is always filled before a valid one is evicted. A write access to a page whose cached dirty attribute is clear is reported as a miss. This sends the access to the walker, which then sets the dirty bit in memory and refills the entry.

Top module: `vpage_tlb`

## Requirements
- R1: After a cycle with reset high, every lookup misses until a fill has been accepted.
- R2: A lookup is combinational on the stored state. With lk_req high and a valid entry for lk_vpn, lk_hit is 1 in the same cycle, and lk_pfn, lk_wr_ok, lk_user and lk_dirty carry the filled values. Whenever lk_hit is 0, all four of those outputs are 0.
- R3: The set index is lk_vpn[3:0] and the tag is lk_vpn[19:4]. Up to four translations with distinct tags and the same index are held together. A page number that differs only in its index bits does not hit on another set's entry.
- R4: A fill into a set that has an invalid way uses the lowest-numbered invalid way. Only a fill into a full set evicts a valid entry.
- R5: Each set has a three-bit replacement tree {t2,t1,t0}, cleared by reset and flush. The victim is way t1 when t0=0 and way 2+t2 when t0=1. Touching way 0 or 1 sets t0=1 and sets t1 to 1 for way 0 and 0 for way 1. Touching way 2 or 3 sets t0=0 and sets t2 to 1 for way 2 and 0 for way 3. An accepted fill touches the way it writes. Otherwise a reported hit touches its way.
- R6: A lookup with lk_write high that matches an entry whose dirty attribute is 0 reports a miss and touches nothing. The same lookup with lk_write low hits.
- R7: A fill whose page number is already cached overwrites that way. No other entry of the set is disturbed.
- R8: A flush pulse invalidates every entry from the next cycle on.
- R9: When flush and fill are high in the same cycle, the fill is dropped.
- R10: With lk_req low, lk_hit is 0 and the replacement state is unchanged.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill. The fill becomes visible to lookups one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries (pulsed on page-table base change) |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found and usable for this access |
| lk_pfn | output | 20 | Physical frame number on hit |
| lk_wr_ok | output | 1 | Cached writable attribute on hit |
| lk_user | output | 1 | Cached user-access attribute on hit |
| lk_dirty | output | 1 | Cached dirty attribute on hit |
| fl_en | input | 1 | Install a translation |
| fl_vpn | input | 20 | Virtual page number being installed |
| fl_pfn | input | 20 | Physical frame number being installed |
| fl_wr_ok | input | 1 | Writable attribute being installed |
| fl_user | input | 1 | User-access attribute being installed |
| fl_dirty | input | 1 | Dirty attribute being installed |

## Verification
Lookup results are due in the same cycle their inputs are applied. The effects of a fill or a flush, including changes to the replacement trees, are due on the first lookup after the next rising edge. The bench drives every input just after a falling edge and samples the lookup outputs 2 ns later, before the following rising edge. It compares them with a reference model that still holds the pre-edge state. Only after that comparison does it apply that cycle's flush, fill or hit to the model, at the same edge the design registers them. This makes the same-cycle fill and lookup case, and the flush-with-fill case, fall out of the same ordering.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int TREE_W = WAYS - 1;

  typedef struct packed {
    logic wr_ok;
    logic user;
    logic dirty;
  } perm_t;

  // Victim chosen by a three-bit replacement tree.
  function automatic logic [WAY_W-1:0] tree_victim(input logic [TREE_W-1:0] t);
    logic [WAY_W-1:0] v;
    if (!t[0]) v = {1'b0, t[1]};
    else       v = {1'b1, t[2]};
    return v;
  endfunction

  // Point the tree away from the way just used.
  function automatic logic [TREE_W-1:0] tree_touch(input logic [TREE_W-1:0] t,
                                                   input logic [WAY_W-1:0]  w);
    logic [TREE_W-1:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 16,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [PFN_W-1:0] w_pfn,
  input  perm_t            w_perm,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [TAG_W-1:0] a_tag,
  output logic [PFN_W-1:0] a_pfn,
  output perm_t            a_perm,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag
);

  // Payload arrays carry no reset so they can map onto RAM.
  logic [TAG_W-1:0] tag_mem  [SETS];
  logic [PFN_W-1:0] pfn_mem  [SETS];
  perm_t            perm_mem [SETS];
  logic [SETS-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx]  <= w_tag;
      pfn_mem[w_idx]  <= w_pfn;
      perm_mem[w_idx] <= w_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (we)      valid_q[w_idx] <= 1'b1;
  end

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_pfn   = pfn_mem[a_idx];
  assign a_perm  = perm_mem[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_mem[b_idx];

endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
  import tlb_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            match,
  output logic [WAY_W-1:0]           match_way
);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    match_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) match_way = WAY_W'(i);
    end
  end

endmodule

// File: rtl/tlb_plru_state.sv
module tlb_plru_state
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             upd,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WAY_W-1:0] q_victim
);

  logic [TREE_W-1:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd) begin
      tree_q[upd_idx] <= tree_touch(tree_q[upd_idx], upd_way);
    end
  end

  assign q_victim = tree_victim(tree_q[q_idx]);

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import tlb_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter int SET_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_req,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr_ok,
  output logic             lk_user,
  output logic             lk_dirty,
  input  logic             fl_en,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PFN_W-1:0] fl_pfn,
  input  logic             fl_wr_ok,
  input  logic             fl_user,
  input  logic             fl_dirty
);

  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = VPN_W - SET_BITS;

  logic [SET_BITS-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0]    lk_tag, fl_tag;

  assign lk_idx = lk_vpn[SET_BITS-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_BITS];
  assign fl_idx = fl_vpn[SET_BITS-1:0];
  assign fl_tag = fl_vpn[VPN_W-1:SET_BITS];

  logic [WAYS-1:0]            a_valid, b_valid, way_we;
  logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
  logic [WAYS-1:0][PFN_W-1:0] a_pfn;
  perm_t [WAYS-1:0]           a_perm;
  perm_t                      fl_perm;
  logic                       fill_go;

  assign fl_perm = '{wr_ok: fl_wr_ok, user: fl_user, dirty: fl_dirty};
  assign fill_go = fl_en && !flush;   // flush wins over fill

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlb_way_store #(
      .SETS (SETS), .IDX_W(SET_BITS), .TAG_W(TAG_W), .PFN_W(PFN_W)
    ) u_store (
      .clk    (clk),
      .rst    (rst),
      .flush  (flush),
      .we     (way_we[g]),
      .w_idx  (fl_idx),
      .w_tag  (fl_tag),
      .w_pfn  (fl_pfn),
      .w_perm (fl_perm),
      .a_idx  (lk_idx),
      .a_valid(a_valid[g]),
      .a_tag  (a_tag[g]),
      .a_pfn  (a_pfn[g]),
      .a_perm (a_perm[g]),
      .b_idx  (fl_idx),
      .b_valid(b_valid[g]),
      .b_tag  (b_tag[g])
    );
  end

  // Lookup side
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  perm_t            hit_perm;
  logic             hit_any, dirty_block, hit_ok;

  tlb_tag_match #(.TAG_W(TAG_W)) u_lk_match (
    .valid    (a_valid),
    .tags     (a_tag),
    .key      (lk_tag),
    .match    (hit_vec),
    .match_way(hit_way)
  );

  assign hit_any     = |hit_vec;
  assign hit_perm    = a_perm[hit_way];
  assign dirty_block = lk_write && !hit_perm.dirty;
  assign hit_ok      = lk_req && hit_any && !dirty_block;

  assign lk_hit   = hit_ok;
  assign lk_pfn   = hit_ok ? a_pfn[hit_way] : '0;
  assign lk_wr_ok = hit_ok && hit_perm.wr_ok;
  assign lk_user  = hit_ok && hit_perm.user;
  assign lk_dirty = hit_ok && hit_perm.dirty;

  // Fill side
  logic [WAYS-1:0]  dup_vec;
  logic [WAY_W-1:0] dup_way, free_way, victim_way, fill_way;
  logic             free_any;

  tlb_tag_match #(.TAG_W(TAG_W)) u_fl_match (
    .valid    (b_valid),
    .tags     (b_tag),
    .key      (fl_tag),
    .match    (dup_vec),
    .match_way(dup_way)
  );

  always_comb begin
    free_way = '0;
    free_any = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!b_valid[i]) begin
        free_way = WAY_W'(i);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    if (|dup_vec)      fill_way = dup_way;
    else if (free_any) fill_way = free_way;
    else               fill_way = victim_way;
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_we
    assign way_we[g] = fill_go && (fill_way == WAY_W'(g));
  end

  // Replacement state: an accepted fill owns the update port.
  logic                plru_upd;
  logic [SET_BITS-1:0] plru_idx;
  logic [WAY_W-1:0]    plru_way;

  assign plru_upd = fill_go || hit_ok;
  assign plru_idx = fill_go ? fl_idx   : lk_idx;
  assign plru_way = fill_go ? fill_way : hit_way;

  tlb_plru_state #(.SETS(SETS), .IDX_W(SET_BITS)) u_plru (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .upd     (plru_upd),
    .upd_idx (plru_idx),
    .upd_way (plru_way),
    .q_idx   (fl_idx),
    .q_victim(victim_way)
  );

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             lk_req,
  input logic             lk_write,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic [PFN_W-1:0] lk_pfn,
  input logic             lk_dirty,
  input logic             fl_en,
  input logic [VPN_W-1:0] fl_vpn,
  input logic [PFN_W-1:0] fl_pfn,
  input logic [3:0]       hit_vec
);

  assert_empty_after_reset_R1: assert property (@(posedge clk)
    rst |=> !lk_hit);

  assert_fill_visible_R11: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !lk_write && !$past(rst) && $past(fl_en) && !$past(flush)
     && lk_vpn == $past(fl_vpn)) |-> (lk_hit && lk_pfn == $past(fl_pfn)));

  assert_miss_outputs_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pfn == '0 && !lk_dirty));

  assert_write_needs_dirty_R6: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_write) |-> lk_dirty);

  assert_no_duplicate_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);

  assert_idle_no_hit_R10: assert property (@(posedge clk) disable iff (rst)
    !lk_req |-> !lk_hit);

endmodule

bind vpage_tlb tlb_checker #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .flush   (flush),
  .lk_req  (lk_req),
  .lk_write(lk_write),
  .lk_vpn  (lk_vpn),
  .lk_hit  (lk_hit),
  .lk_pfn  (lk_pfn),
  .lk_dirty(lk_dirty),
  .fl_en   (fl_en),
  .fl_vpn  (fl_vpn),
  .fl_pfn  (fl_pfn),
  .hit_vec (hit_vec)
);

// File: tb/sim_vpage_tlb.sv
module sim_vpage_tlb;

  localparam int NS = 16;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst, flush, lk_req, lk_write, fl_en, fl_wr_ok, fl_user, fl_dirty;
  logic [19:0] lk_vpn, fl_vpn, fl_pfn, lk_pfn;
  logic        lk_hit, lk_wr_ok, lk_user, lk_dirty;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vpage_tlb u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_req(lk_req), .lk_write(lk_write), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr_ok(lk_wr_ok),
    .lk_user(lk_user), .lk_dirty(lk_dirty),
    .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
    .fl_wr_ok(fl_wr_ok), .fl_user(fl_user), .fl_dirty(fl_dirty)
  );

  // Reference model built from the requirements
  bit        mv [NS][NW];
  bit [15:0] mt [NS][NW];
  bit [19:0] mp [NS][NW];
  bit [2:0]  ma [NS][NW];   // {wr_ok,user,dirty}
  bit [2:0]  mb [NS];

  function automatic bit [2:0] m_touch(bit [2:0] t, int w);
    bit [2:0] n = t;
    if (w < 2) begin n[0] = 1; n[1] = (w == 0); end
    else       begin n[0] = 0; n[2] = (w == 2); end
    return n;
  endfunction

  function automatic int m_find(bit [19:0] v);
    for (int w = 0; w < NW; w++)
      if (mv[v[3:0]][w] && mt[v[3:0]][w] == v[19:4]) return w;
    return -1;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < NS; s++) begin
      mb[s] = 0;
      for (int w = 0; w < NW; w++) mv[s][w] = 0;
    end
  endtask

  task automatic chk(string req, bit [63:0] act, bit [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive after negedge, compare, advance model at the edge.
  task automatic step(string req, bit f, bit fe, bit [19:0] fv, bit [19:0] fp,
                      bit [2:0] fa, bit rq, bit wr, bit [19:0] lv);
    int  w, s, fw;
    bit  eh;
    flush = f; fl_en = fe; fl_vpn = fv; fl_pfn = fp;
    {fl_wr_ok, fl_user, fl_dirty} = fa;
    lk_req = rq; lk_write = wr; lk_vpn = lv;
    #2;
    w  = m_find(lv);
    s  = lv[3:0];
    eh = rq && (w >= 0) && !(wr && !ma[s][(w<0)?0:w][0]);
    chk(req, {63'd0, lk_hit}, {63'd0, eh});
    if (eh) chk(req, {lk_pfn, lk_wr_ok, lk_user, lk_dirty}, {mp[s][w], ma[s][w]});
    else    chk(req, {lk_pfn, lk_wr_ok, lk_user, lk_dirty}, 64'd0);
    if (f) m_clear();
    else if (fe) begin
      int fs = fv[3:0];
      fw = m_find(fv);
      if (fw < 0) for (int k = NW - 1; k >= 0; k--) if (!mv[fs][k]) fw = k;
      if (fw < 0) fw = mb[fs][0] ? (2 + mb[fs][2]) : mb[fs][1];
      mv[fs][fw] = 1; mt[fs][fw] = fv[19:4]; mp[fs][fw] = fp; ma[fs][fw] = fa;
      mb[fs] = m_touch(mb[fs], fw);
    end else if (eh) mb[s] = m_touch(mb[s], w);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(string req, bit [19:0] v, bit [19:0] p, bit [2:0] a);
    step(req, 0, 1, v, p, a, 0, 0, 20'h0);
  endtask

  task automatic look(string req, bit [19:0] v, bit wr);
    step(req, 0, 0, 20'h0, 20'h0, 3'b0, 1, wr, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1; flush = 0; fl_en = 0; lk_req = 0; lk_write = 0;
    lk_vpn = 0; fl_vpn = 0; fl_pfn = 0; fl_wr_ok = 0; fl_user = 0; fl_dirty = 0;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: empty after reset
    look("R1", 20'h00000, 0);
    look("R1", 20'hABCD3, 0);
    // R11: same-cycle lookup sees old contents; R2 next cycle
    step("R11", 0, 1, 20'h12345, 20'hABCDE, 3'b101, 1, 0, 20'h12345);
    look("R2", 20'h12345, 0);
    look("R2", 20'h12345, 1);
    // R3: four tags share set 5; neighbour set misses
    for (int i = 1; i <= 4; i++) fill("R3", {16'(i), 4'h5}, 20'(i * 20'h111), 3'b111);
    for (int i = 1; i <= 4; i++) look("R3", {16'(i), 4'h5}, 0);
    look("R3", {16'd1, 4'h6}, 0);
    // R4/R5: fill A..D into set 7, hit A, fill E -> C evicted
    for (int i = 0; i < 4; i++) fill("R4", {16'(i + 20), 4'h7}, 20'(i + 100), 3'b111);
    look("R5", {16'd20, 4'h7}, 0);
    fill("R5", {16'd30, 4'h7}, 20'h00555, 3'b111);
    look("R5", {16'd22, 4'h7}, 0);
    look("R5", {16'd20, 4'h7}, 0);
    look("R5", {16'd30, 4'h7}, 0);
    // R6: clean page blocks writes only
    fill("R6", 20'h77778, 20'h0F0F0, 3'b110);
    look("R6", 20'h77778, 1);
    look("R6", 20'h77778, 0);
    // R7: refill of a cached page overwrites in place
    fill("R7", {16'd21, 4'h7}, 20'h0BEEF, 3'b011);
    for (int i = 20; i <= 23; i++) look("R7", {16'(i), 4'h7}, 0);
    look("R7", {16'd30, 4'h7}, 0);
    // R10: idle lookup does not touch the tree
    for (int i = 0; i < 4; i++) fill("R10", {16'(i + 40), 4'h9}, 20'(i + 7), 3'b001);
    step("R10", 0, 0, 20'h0, 20'h0, 3'b0, 0, 0, {16'd40, 4'h9});
    fill("R10", {16'd50, 4'h9}, 20'h00099, 3'b001);
    look("R10", {16'd40, 4'h9}, 0);
    // R8: flush empties everything
    step("R8", 1, 0, 20'h0, 20'h0, 3'b0, 1, 0, 20'h12345);
    look("R8", 20'h12345, 0);
    look("R8", {16'd50, 4'h9}, 0);
    // R9: flush beats fill
    step("R9", 1, 1, 20'h4444A, 20'h3333C, 3'b111, 0, 0, 20'h0);
    look("R9", 20'h4444A, 0);
    // Random traffic over a small page pool
    for (int n = 0; n < 4000; n++) begin
      bit [19:0] lv = {16'($urandom_range(0, 6)), 4'($urandom_range(0, 3))};
      bit [19:0] fv = {16'($urandom_range(0, 6)), 4'($urandom_range(0, 3))};
      step("R5", ($urandom_range(0, 59) == 0), ($urandom_range(0, 1) == 1), fv,
           20'($urandom), 3'($urandom), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 2) == 0), lv);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule